// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Status Byte

This block is the arithmetic and logic datapath of a small accumulator machine. It holds an accumulator register and a status byte. On each enabled clock edge it combines the accumulator with a second operand taken from a data input, which stands for a value read from memory or from a register. A 3-bit operation code selects one of eight operations. The result is written back into the accumulator, and the status byte is refreshed with sign, zero, half-carry, parity and carry information about that result.

Compare is the one operation that changes only the status byte. It works out the flags exactly as a subtraction would and leaves the accumulator unchanged. Subtract with borrow and add with carry take the carry flag stored from the previous operation, so several of these operations can be chained to work on numbers wider than eight bits.

The operand width and the style of the adder are parameters. The status byte is always eight bits wide, with a fixed layout.

Top module: `alu8_acc_unit`

## Requirements
- R1: When `en` is high, the rising edge writes the result into `acc_q`. The `op` encodings are:
  - 0: add, A+D
  - 1: add with carry, A+D+CY
  - 2: subtract, A-D
  - 3: subtract with borrow, A-D-CY
  - 4: compare
  - 5: AND
  - 6: OR
  - 7: XOR

  Here A is `acc_q`, D is `din` and CY is the stored carry flag.
- R2: When `en` is low, neither `acc_q` nor `flags_q` changes, whatever `op` and `din` hold.
- R3: A high `rst` at a rising edge sets `acc_q` to 0x00 and `flags_q` to 0x02. Reset takes priority over `en`.
- R4: The bit positions in `flags_q` are:
  - bit 7: sign
  - bit 6: zero
  - bit 4: half-carry
  - bit 2: parity
  - bit 0: carry

  Bit 1 always reads 1, and bits 3 and 5 always read 0.
- R5: After an enabled operation, the sign flag equals bit 7 of the 8-bit result, and the zero flag is 1 exactly when the result is 0x00.
- R6: After an enabled operation, the parity flag is 1 when the result holds an even number of 1 bits.
- R7: For add and add with carry, the carry flag is the carry out of bit 7. For subtract, subtract with borrow and compare, it is 1 when a borrow occurs, that is when A < D + borrow-in.
- R8: The half-carry flag is the carry out of bit 3 in the adder. For additions this is A[3:0]+D[3:0]+cin > 15. For subtractions and compare it is A[3:0]+(~D)[3:0]+(1-borrow-in) > 15.
- R9: Compare updates all flags as subtract would and leaves `acc_q` unchanged.
- R10: AND, OR and XOR clear the carry flag. AND sets the half-carry flag, and OR and XOR clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Executes the selected operation this cycle |
| op | input | 3 | Operation code (see R1) |
| din | input | DATA_W | Second operand |
| acc_q | output | DATA_W | Accumulator register |
| flags_q | output | 8 | Status byte (see R4) |

## Verification
The hardest conditions to reach are the ones that depend on the carry stored by the previous operation. These are subtract with borrow and add with carry where the borrow-in or carry-in itself decides the carry-out or the half-carry, for example 0x00 minus 0x00 with a borrow pending. A mix of operand values chosen purely at random almost never lines these up. The stimulus therefore biases `din` toward the current accumulator value, 0x00 and 0xFF, and it interleaves carry-producing additions with borrow-consuming subtractions. The bench's own model carries the flags from one operation to the next, so every chained case is predicted.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBB = 3'd3,
      OP_CMP = 3'd4,
      OP_AND = 3'd5,
      OP_OR  = 3'd6,
      OP_XOR = 3'd7
   } alu_op_e;

   localparam int FLAG_W   = 8;
   localparam int FLAG_CY  = 0;
   localparam int FLAG_ONE = 1;
   localparam int FLAG_P   = 2;
   localparam int FLAG_AC  = 4;
   localparam int FLAG_Z   = 6;
   localparam int FLAG_S   = 7;

   localparam logic [FLAG_W-1:0] FLAGS_RESET = 8'h02;

   function automatic logic op_is_logic(alu_op_e o);
      return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
   endfunction

   function automatic logic op_is_sub(alu_op_e o);
      return (o == OP_SUB) || (o == OP_SBB) || (o == OP_CMP);
   endfunction

endpackage

// File: rtl/alu8_operand.sv
module alu8_operand
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e            op,
   input  logic [DATA_W-1:0]  din,
   input  logic               cy_in,
   output logic [DATA_W-1:0]  b_op,
   output logic               cin,
   output logic               subtract
);

   always_comb begin
      subtract = op_is_sub(op);
      b_op     = subtract ? ~din : din;
      unique case (op)
         OP_ADC:  cin = cy_in;
         OP_SUB:  cin = 1'b1;
         OP_CMP:  cin = 1'b1;
         OP_SBB:  cin = ~cy_in;
         default: cin = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              c_half
);

   localparam int HI_W = DATA_W - 4;

   if (DATA_W < 5) begin : g_width_check
      $error("alu8_adder: DATA_W must be at least 5");
   end

   if (RIPPLE) begin : g_ripple
      logic [DATA_W:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]   = a[i] ^ b[i] ^ c[i];
         assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
      end
      assign cout   = c[DATA_W];
      assign c_half = c[4];
   end else begin : g_split
      logic [4:0]    lo;
      logic [HI_W:0] hi;
      assign lo     = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0000, cin};
      assign hi     = {1'b0, a[DATA_W-1:4]} + {1'b0, b[DATA_W-1:4]}
                    + {{HI_W{1'b0}}, lo[4]};
      assign sum    = {hi[HI_W-1:0], lo[3:0]};
      assign cout   = hi[HI_W];
      assign c_half = lo[4];
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              half
);

   always_comb begin
      half = 1'b0;
      unique case (op)
         OP_AND:  begin res = a & b; half = 1'b1; end
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic              cy,
   input  logic              half,
   output logic [FLAG_W-1:0] flags
);

   always_comb begin
      flags           = '0;
      flags[FLAG_S]   = res[DATA_W-1];
      flags[FLAG_Z]   = (res == '0);
      flags[FLAG_AC]  = half;
      flags[FLAG_P]   = ~^res;
      flags[FLAG_ONE] = 1'b1;
      flags[FLAG_CY]  = cy;
   end

endmodule

// File: rtl/alu8_acc_unit.sv
module alu8_acc_unit
   import alu8_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] acc_q,
   output logic [FLAG_W-1:0] flags_q
);

   if (DATA_W < 5) begin : g_width_check
      $error("alu8_acc_unit: DATA_W must be at least 5");
   end

   alu_op_e           op_e;
   logic [DATA_W-1:0] b_op;
   logic              cin;
   logic              subtract;
   logic [DATA_W-1:0] sum;
   logic              cout;
   logic              c_half;
   logic [DATA_W-1:0] log_res;
   logic              log_half;
   logic [DATA_W-1:0] result;
   logic              cy_nxt;
   logic              half_nxt;
   logic [FLAG_W-1:0] flags_nxt;

   assign op_e = alu_op_e'(op);

   alu8_operand #(.DATA_W(DATA_W)) i_operand (
      .op       (op_e),
      .din      (din),
      .cy_in    (flags_q[FLAG_CY]),
      .b_op     (b_op),
      .cin      (cin),
      .subtract (subtract)
   );

   alu8_adder #(.DATA_W(DATA_W), .RIPPLE(RIPPLE_ADD)) i_adder (
      .a      (acc_q),
      .b      (b_op),
      .cin    (cin),
      .sum    (sum),
      .cout   (cout),
      .c_half (c_half)
   );

   alu8_logic #(.DATA_W(DATA_W)) i_logic (
      .op   (op_e),
      .a    (acc_q),
      .b    (din),
      .res  (log_res),
      .half (log_half)
   );

   always_comb begin
      if (op_is_logic(op_e)) begin
         result   = log_res;
         cy_nxt   = 1'b0;
         half_nxt = log_half;
      end else begin
         result   = sum;
         cy_nxt   = subtract ? ~cout : cout;
         half_nxt = c_half;
      end
   end

   alu8_flagpack #(.DATA_W(DATA_W)) i_flagpack (
      .res   (result),
      .cy    (cy_nxt),
      .half  (half_nxt),
      .flags (flags_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         flags_q <= FLAGS_RESET;
      end else if (en) begin
         flags_q <= flags_nxt;
         if (op_e != OP_CMP) acc_q <= result;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc_q) && $stable(flags_q)); // R2

   AST_ZERO_TRACKS_ACC: assert property (@(posedge clk) disable iff (rst)
      en && op_e != OP_CMP |=> flags_q[FLAG_Z] == (acc_q == '0)); // R5

   AST_SIGN_TRACKS_ACC: assert property (@(posedge clk) disable iff (rst)
      en && op_e != OP_CMP |=> flags_q[FLAG_S] == acc_q[DATA_W-1]); // R5

   AST_PARITY_TRACKS_ACC: assert property (@(posedge clk) disable iff (rst)
      en && op_e != OP_CMP |=> flags_q[FLAG_P] == ~^acc_q); // R6

   AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
      en && op_e == OP_CMP |=> acc_q == $past(acc_q)); // R9

   AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (rst)
      en && op_e == OP_CMP && din == acc_q |=> flags_q[FLAG_Z] && !flags_q[FLAG_CY]); // R9

   AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
      en && op_is_logic(op_e) |=> !flags_q[FLAG_CY]); // R10

   AST_AND_HALF: assert property (@(posedge clk) disable iff (rst)
      en && op_e == OP_AND |=> flags_q[FLAG_AC]); // R10

   AST_LAYOUT_BITS: assert property (@(posedge clk) disable iff (rst)
      en |=> flags_q[FLAG_ONE] && !flags_q[3] && !flags_q[5]); // R4

endmodule

// File: tb/test_alu8_acc_unit.sv
`timescale 1ns/1ps
module test_alu8_acc_unit;

   logic       clk = 1'b0;
   logic       rst;
   logic       en;
   logic [2:0] op;
   logic [7:0] din;
   logic [7:0] acc_q;
   logic [7:0] flags_q;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] m_acc;
   logic [7:0] m_flg;

   always #2.5 clk = ~clk;

   alu8_acc_unit i_alu8_acc_unit (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .op      (op),
      .din     (din),
      .acc_q   (acc_q),
      .flags_q (flags_q)
   );

   function automatic logic [15:0] model(logic [7:0] a, logic [7:0] f,
                                         logic [2:0] o, logic [7:0] d);
      int r;
      int ci;
      logic cy;
      logic ac;
      logic [7:0] res;
      logic [7:0] nf;
      cy = 1'b0;
      ac = 1'b0;
      r  = 0;
      case (o)
         3'd0, 3'd1: begin
            ci = (o == 3'd1) ? int'(f[0]) : 0;
            r  = int'(a) + int'(d) + ci;
            cy = (r > 255);
            ac = (int'(a & 8'h0F) + int'(d & 8'h0F) + ci) > 15;
         end
         3'd2, 3'd3, 3'd4: begin
            ci = (o == 3'd3) ? int'(f[0]) : 0;
            r  = int'(a) - int'(d) - ci;
            cy = (r < 0);
            ac = (int'(a & 8'h0F) + int'(~d & 8'h0F) + (1 - ci)) > 15;
         end
         3'd5: begin r = int'(a & d); ac = 1'b1; end
         3'd6: r = int'(a | d);
         default: r = int'(a ^ d);
      endcase
      res = r[7:0];
      nf  = {res[7], (res == 8'h00), 1'b0, ac, 1'b0, ~^res, 1'b1, cy};
      return {(o == 3'd4) ? a : res, nf};
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (op %0d din %h)",
                  tag, what, act, exp, op, din);
      end
   endtask

   // Called at a falling edge; applies inputs, passes one rising edge, checks.
   task automatic step(logic r, logic e, logic [2:0] o, logic [7:0] d);
      string ta;
      string tf;
      logic [15:0] nx;
      rst = r; en = e; op = o; din = d;
      if (r) begin
         nx = {8'h00, 8'h02}; ta = "R3"; tf = "R3";
      end else if (!e) begin
         nx = {m_acc, m_flg}; ta = "R2"; tf = "R2";
      end else begin
         nx = model(m_acc, m_flg, o, d);
         ta = (o == 3'd4) ? "R9" : "R1";
         tf = (o >= 3'd5) ? "R10" : ((o == 3'd4) ? "R9" : "R7");
      end
      @(posedge clk);
      @(negedge clk);
      m_acc = nx[15:8];
      m_flg = nx[7:0];
      chk(ta, "acc", acc_q, m_acc);
      chk(tf, "flags", flags_q, m_flg);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [2:0] o;
      void'($urandom(32'd24681));
      rst = 1'b1; en = 1'b0; op = 3'd0; din = 8'h00;
      m_acc = 8'h00; m_flg = 8'h02;
      @(negedge clk);
      step(1'b1, 1'b0, 3'd0, 8'h00);
      chk("R3", "reset flags", flags_q, 8'h02);

      // Directed corners
      step(1'b0, 1'b1, 3'd0, 8'h0F);
      step(1'b0, 1'b1, 3'd0, 8'h01);                    // 0F+01: half-carry
      chk("R8", "half-carry add", flags_q, 8'h12);
      step(1'b0, 1'b1, 3'd0, 8'hF0);                    // 10+F0 -> 00 with carry
      chk("R5", "zero/carry", flags_q, 8'h47);
      step(1'b0, 1'b1, 3'd2, 8'h01);                    // 00-01 -> FF borrow
      chk("R7", "borrow", flags_q, 8'h87);
      chk("R5", "sign result", acc_q, 8'hFF);
      step(1'b0, 1'b1, 3'd4, 8'hFF);                    // compare equal
      chk("R9", "compare equal", flags_q, 8'h56);
      chk("R9", "compare acc kept", acc_q, 8'hFF);
      step(1'b0, 1'b1, 3'd5, 8'h0F);                    // AND
      chk("R10", "and flags", flags_q, 8'h16);
      chk("R6", "even parity", flags_q & 8'h04, 8'h04);
      step(1'b0, 1'b1, 3'd6, 8'h10);                    // OR -> 1F odd parity
      chk("R6", "odd parity", flags_q & 8'h04, 8'h00);
      chk("R4", "fixed bits", flags_q & 8'h2A, 8'h02);
      step(1'b0, 1'b0, 3'd0, 8'h55);                    // disabled
      step(1'b0, 1'b1, 3'd0, 8'hFF);                    // sets carry
      step(1'b0, 1'b1, 3'd1, 8'h00);                    // ADC consumes carry
      step(1'b0, 1'b1, 3'd2, 8'h80);
      step(1'b0, 1'b1, 3'd3, 8'h00);                    // SBB with borrow pending
      step(1'b1, 1'b1, 3'd0, 8'h33);                    // reset beats enable
      step(1'b0, 1'b1, 3'd3, 8'h00);

      // Biased random sequence
      for (int i = 0; i < 4000; i++) begin
         case ($urandom % 5)
            0: d = m_acc;
            1: d = 8'h00;
            2: d = 8'hFF;
            default: d = 8'($urandom);
         endcase
         o = 3'($urandom);
         step(($urandom % 100) == 0, ($urandom % 10) != 0, o, d);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule